// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps the running time of a precision time protocol node as a seconds count and a nanoseconds count. On every tick of the local time clock the nanoseconds count grows by a programmed step. The step has an integer part in nanoseconds and a fractional part. The fractional part builds up in an accumulator that wraps at a fixed modulo, and every wrap adds one more nanosecond. The current time is always present on the output pins as a 48-bit seconds value and a 32-bit nanoseconds value, so that stamping or pulse logic next to the block can use it directly.

Control logic in the time clock domain drives a small command port with four operations. It can load a new time, add a signed nanosecond offset, program the step, or clear the time and the accumulator. After an offset has been applied, a flag stays raised until it is cleared. Logic in a second clock domain reads the time through a toggle request/acknowledge handshake. The snapshot is taken in one time-clock cycle and held while the reader picks it up, so the seconds and nanoseconds always belong together.

Top module: `tod_clock_core`

## Requirements
- R1: After reset the time output is 0 s / 0 ns, `adj_done` is low, `rd_valid` is low, and the step is zero, so the time stays frozen until a step is programmed.
- R2: A command with `wr_op` = 0 (load) sets `tod_sec` to `wr_sec` and `tod_ns` to `wr_ns` in the next cycle, both fields together and with no step added.
- R3: With `wr_op` = 2 (step), the step is loaded from the integer nanoseconds in `wr_ns[7:0]` and the fraction in `wr_frac`. Once the two-stage pipeline has filled, `tod_ns` grows each cycle by the integer part, plus one in each cycle where the accumulator wraps.
- R4: The fraction accumulator wraps at the fixed modulo 256,000,000,000, which no command can change. A fraction of 64,000,000,000 therefore adds exactly one nanosecond in every four cycles, and a fraction of 128,000,000,000 adds one in every two cycles.
- R5: When the nanoseconds sum reaches 1,000,000,000 or more, 1,000,000,000 is subtracted and `tod_sec` goes up by one in the same cycle. `tod_ns` never shows a value of 1,000,000,000 or more.
- R6: A command with `wr_op` = 1 (offset) adds `wr_ns`, read as a two's-complement number, to the time exactly once. A result below zero borrows one second and a result of one second or more carries one second.
- R7: `adj_done` rises in the cycle after an offset command and stays high until a `done_clr` pulse. An offset and a clear in the same cycle leave the flag high.
- R8: A command with `wr_op` = 3 (clear) zeroes the time and the fraction accumulator in the next cycle and keeps the programmed step. The time then resumes at the same rate.
- R9: A one-cycle `rd_req` in the reader domain is answered by a one-cycle `rd_valid` pulse, with `rd_sec`/`rd_ns` holding a single coherent snapshot. A request made while an earlier one is still outstanding is dropped and gets no answer of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rtc_clk | input | 1 | Time clock |
| rtc_rst_n | input | 1 | Asynchronous active-low reset, time domain |
| wr_en | input | 1 | Command strobe |
| wr_op | input | 2 | Operation: 0 load, 1 offset, 2 step, 3 clear |
| wr_sec | input | 48 | Seconds to load |
| wr_ns | input | 32 | Nanoseconds to load, signed offset, or integer step in [7:0] |
| wr_frac | input | 38 | Fraction of the step, in units of 1/256e9 ns |
| done_clr | input | 1 | Clears the offset-done flag |
| adj_done | output | 1 | Offset applied, held until cleared |
| tod_sec | output | 48 | Current seconds |
| tod_ns | output | 32 | Current nanoseconds |
| cpu_clk | input | 1 | Reader clock |
| cpu_rst_n | input | 1 | Asynchronous active-low reset, reader domain |
| rd_req | input | 1 | Snapshot request pulse |
| rd_valid | output | 1 | Snapshot ready pulse |
| rd_sec | output | 48 | Snapshot seconds |
| rd_ns | output | 32 | Snapshot nanoseconds |

## Verification
The checker assumes that:
- a loaded nanoseconds value is below one billion;
- an offset is smaller than one billion in magnitude;
- a programmed fraction is below the modulo.

Under those limits, every sum the time register can form needs at most one correction per cycle. The rollover property depends on this: a drop in nanoseconds with no command in the previous cycle must come with exactly one more second. The stimulus only loads values below one billion, uses offsets of a few thousand nanoseconds, and uses fractions of one quarter and one half of the modulo. Reads are made only while the step is zero, so the expected snapshot is known exactly.

// File: rtl/tod_pkg.sv
package tod_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_SHIFT = 2'd1,
      OP_STEP  = 2'd2,
      OP_CLEAR = 2'd3
   } tod_op_e;

   localparam logic [63:0] NS_PER_SEC = 64'd1_000_000_000;
   localparam logic [63:0] ACC_MODULO = 64'd256_000_000_000;
endpackage

// File: rtl/tod_bit_sync.sv
module tod_bit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tod_frac_acc.sv
module tod_frac_acc import tod_pkg::*; #(
   parameter int INC_INT_W = 8,
   parameter int FRAC_W    = 38,
   parameter bit PIPE_STEP = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 inc_load,
   input  logic                 clr,
   input  logic [INC_INT_W-1:0] inc_int_in,
   input  logic [FRAC_W-1:0]    inc_frac_in,
   output logic [INC_INT_W:0]   step
);
   localparam logic [FRAC_W:0] MOD_L = (FRAC_W+1)'(ACC_MODULO);

   logic [INC_INT_W-1:0] inc_int_q;
   logic [FRAC_W-1:0]    inc_frac_q;
   logic [FRAC_W-1:0]    acc_q;
   logic [FRAC_W-1:0]    acc_d;
   logic [FRAC_W:0]      sum;
   logic                 wrap;
   logic [INC_INT_W:0]   step_d;

   // step register: only a full reset clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inc_int_q  <= '0;
         inc_frac_q <= '0;
      end else if (inc_load) begin
         inc_int_q  <= inc_int_in;
         inc_frac_q <= inc_frac_in;
      end
   end

   always_comb begin
      sum    = {1'b0, acc_q} + {1'b0, inc_frac_q};
      wrap   = (sum >= MOD_L);
      acc_d  = wrap ? FRAC_W'(sum - MOD_L) : sum[FRAC_W-1:0];
      step_d = {1'b0, inc_int_q} + {{INC_INT_W{1'b0}}, wrap};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (clr) acc_q <= '0;
      else          acc_q <= acc_d;
   end

   generate
      if (PIPE_STEP) begin : g_pipe
         logic [INC_INT_W:0] step_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   step_q <= '0;
            else if (clr) step_q <= '0;
            else          step_q <= step_d;
         end
         assign step = step_q;
      end else begin : g_comb
         assign step = step_d;
      end
   endgenerate
endmodule

// File: rtl/tod_time_reg.sv
module tod_time_reg import tod_pkg::*; #(
   parameter int SEC_W  = 48,
   parameter int NS_W   = 32,
   parameter int STEP_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STEP_W-1:0] step,
   input  logic              wr_en,
   input  logic [1:0]        wr_op,
   input  logic [SEC_W-1:0]  wr_sec,
   input  logic [NS_W-1:0]   wr_ns,
   input  logic              done_clr,
   output logic [SEC_W-1:0]  sec_q,
   output logic [NS_W-1:0]   ns_q,
   output logic              adj_done
);
   localparam int S = NS_W + 2;
   localparam logic signed [S-1:0] BILLION = S'(NS_PER_SEC);

   logic                    is_shift;
   logic signed [S-1:0]     off;
   logic signed [S-1:0]     base;
   logic signed [S-1:0]     tot;
   logic [NS_W-1:0]         ns_nx;
   logic [SEC_W-1:0]        sec_nx;

   assign is_shift = wr_en && (wr_op == OP_SHIFT);

   always_comb begin
      off = '0;
      if (is_shift) off = {{2{wr_ns[NS_W-1]}}, wr_ns};
      base = $signed({2'b00, ns_q}) + $signed({{(S-STEP_W){1'b0}}, step});
      tot  = base + off;
      if (tot < 0) begin
         ns_nx  = NS_W'(tot + BILLION);
         sec_nx = sec_q - 1'b1;
      end else if (tot >= BILLION) begin
         ns_nx  = NS_W'(tot - BILLION);
         sec_nx = sec_q + 1'b1;
      end else begin
         ns_nx  = NS_W'(tot);
         sec_nx = sec_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= '0;
         ns_q  <= '0;
      end else if (wr_en && (wr_op == OP_LOAD)) begin
         sec_q <= wr_sec;
         ns_q  <= wr_ns;
      end else if (wr_en && (wr_op == OP_CLEAR)) begin
         sec_q <= '0;
         ns_q  <= '0;
      end else begin
         sec_q <= sec_nx;
         ns_q  <= ns_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        adj_done <= 1'b0;
      else if (is_shift) adj_done <= 1'b1;
      else if (done_clr) adj_done <= 1'b0;
   end
endmodule

// File: rtl/tod_snap_cdc.sv
module tod_snap_cdc #(
   parameter int SEC_W       = 48,
   parameter int NS_W        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             rtc_clk,
   input  logic             rtc_rst_n,
   input  logic [SEC_W-1:0] sec_in,
   input  logic [NS_W-1:0]  ns_in,
   input  logic             cpu_clk,
   input  logic             cpu_rst_n,
   input  logic             rd_req,
   output logic             rd_valid,
   output logic [SEC_W-1:0] rd_sec,
   output logic [NS_W-1:0]  rd_ns
);
   logic req_tgl, req_s, req_prev;
   logic ack_tgl, ack_s, ack_prev;
   logic busy;
   logic ack_edge;
   logic [SEC_W-1:0] hold_sec;
   logic [NS_W-1:0]  hold_ns;

   tod_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(rtc_clk), .rst_n(rtc_rst_n), .d(req_tgl), .q(req_s));

   tod_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(cpu_clk), .rst_n(cpu_rst_n), .d(ack_tgl), .q(ack_s));

   // reader side
   assign ack_edge = ack_s ^ ack_prev;

   always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
      if (!cpu_rst_n) begin
         req_tgl  <= 1'b0;
         busy     <= 1'b0;
         ack_prev <= 1'b0;
         rd_valid <= 1'b0;
      end else begin
         ack_prev <= ack_s;
         rd_valid <= ack_edge;
         if (ack_edge) begin
            busy <= 1'b0;
         end else if (rd_req && !busy) begin
            busy    <= 1'b1;
            req_tgl <= ~req_tgl;
         end
      end
   end

   // time side: capture both fields in one cycle
   always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n) begin
         req_prev <= 1'b0;
         ack_tgl  <= 1'b0;
         hold_sec <= '0;
         hold_ns  <= '0;
      end else begin
         req_prev <= req_s;
         if (req_s ^ req_prev) begin
            hold_sec <= sec_in;
            hold_ns  <= ns_in;
            ack_tgl  <= ~ack_tgl;
         end
      end
   end

   assign rd_sec = hold_sec;
   assign rd_ns  = hold_ns;
endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core import tod_pkg::*; #(
   parameter int SEC_W       = 48,
   parameter int NS_W        = 32,
   parameter int INC_INT_W   = 8,
   parameter int FRAC_W      = 38,
   parameter int SYNC_STAGES = 2,
   parameter bit PIPE_STEP   = 1'b1
) (
   input  logic              rtc_clk,
   input  logic              rtc_rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_op,
   input  logic [SEC_W-1:0]  wr_sec,
   input  logic [NS_W-1:0]   wr_ns,
   input  logic [FRAC_W-1:0] wr_frac,
   input  logic              done_clr,
   output logic              adj_done,
   output logic [SEC_W-1:0]  tod_sec,
   output logic [NS_W-1:0]   tod_ns,
   input  logic              cpu_clk,
   input  logic              cpu_rst_n,
   input  logic              rd_req,
   output logic              rd_valid,
   output logic [SEC_W-1:0]  rd_sec,
   output logic [NS_W-1:0]   rd_ns
);
   localparam int STEP_W = INC_INT_W + 1;

   generate
      if (FRAC_W < 38 || FRAC_W > 62) begin : g_bad_frac
         $error("FRAC_W must hold the accumulator modulo (38..62)");
      end
      if (NS_W < 31) begin : g_bad_ns
         $error("NS_W must hold one billion");
      end
      if (INC_INT_W < 1 || INC_INT_W >= NS_W - 2) begin : g_bad_inc
         $error("INC_INT_W out of range");
      end
      if (SEC_W < 1) begin : g_bad_sec
         $error("SEC_W must be positive");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              step_load;
   logic              acc_clr;
   logic [STEP_W-1:0] step;

   assign step_load = wr_en && (wr_op == OP_STEP);
   assign acc_clr   = wr_en && (wr_op == OP_CLEAR);

   tod_frac_acc #(
      .INC_INT_W(INC_INT_W), .FRAC_W(FRAC_W), .PIPE_STEP(PIPE_STEP)
   ) u_acc (
      .clk(rtc_clk), .rst_n(rtc_rst_n),
      .inc_load(step_load), .clr(acc_clr),
      .inc_int_in(wr_ns[INC_INT_W-1:0]), .inc_frac_in(wr_frac),
      .step(step)
   );

   tod_time_reg #(
      .SEC_W(SEC_W), .NS_W(NS_W), .STEP_W(STEP_W)
   ) u_time (
      .clk(rtc_clk), .rst_n(rtc_rst_n), .step(step),
      .wr_en(wr_en), .wr_op(wr_op), .wr_sec(wr_sec), .wr_ns(wr_ns),
      .done_clr(done_clr),
      .sec_q(tod_sec), .ns_q(tod_ns), .adj_done(adj_done)
   );

   tod_snap_cdc #(
      .SEC_W(SEC_W), .NS_W(NS_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_snap (
      .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n),
      .sec_in(tod_sec), .ns_in(tod_ns),
      .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
      .rd_req(rd_req), .rd_valid(rd_valid),
      .rd_sec(rd_sec), .rd_ns(rd_ns)
   );
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk import tod_pkg::*; #(
   parameter int SEC_W = 48,
   parameter int NS_W  = 32
) (
   input logic             rtc_clk,
   input logic             rtc_rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_op,
   input logic [SEC_W-1:0] wr_sec,
   input logic [NS_W-1:0]  wr_ns,
   input logic             done_clr,
   input logic             adj_done,
   input logic [SEC_W-1:0] tod_sec,
   input logic [NS_W-1:0]  tod_ns,
   input logic             cpu_clk,
   input logic             cpu_rst_n,
   input logic             rd_valid
);
   // R2
   load_both_chk: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
      (wr_en && wr_op == OP_LOAD) |=> (tod_sec == $past(wr_sec) && tod_ns == $past(wr_ns)));

   // R5
   ns_range_chk: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
      64'(tod_ns) < NS_PER_SEC);

   // R5
   sec_carry_chk: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
      (!$past(wr_en) && tod_ns < $past(tod_ns)) |-> (tod_sec == $past(tod_sec) + 1'b1));

   // R7
   done_rise_chk: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
      (wr_en && wr_op == OP_SHIFT) |=> adj_done);

   // R7
   done_keep_chk: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
      (adj_done && !done_clr) |=> adj_done);

   // R7
   done_drop_chk: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
      (done_clr && !(wr_en && wr_op == OP_SHIFT)) |=> !adj_done);

   // R8
   clear_zero_chk: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
      (wr_en && wr_op == OP_CLEAR) |=> (tod_sec == '0 && tod_ns == '0));

   // R9
   valid_pulse_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      rd_valid |=> !rd_valid);
endmodule

bind tod_clock_core tod_clock_chk #(.SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
   .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n), .wr_en(wr_en), .wr_op(wr_op),
   .wr_sec(wr_sec), .wr_ns(wr_ns), .done_clr(done_clr), .adj_done(adj_done),
   .tod_sec(tod_sec), .tod_ns(tod_ns), .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
   .rd_valid(rd_valid)
);

// File: tb/sim_tod_clock_core.sv
module sim_tod_clock_core;
   localparam int SEC_W  = 48;
   localparam int NS_W   = 32;
   localparam int FRAC_W = 38;

   logic rtc_clk = 1'b0;
   logic cpu_clk = 1'b0;
   always #4 rtc_clk = ~rtc_clk;
   always #5 cpu_clk = ~cpu_clk;

   logic              rtc_rst_n = 1'b0, cpu_rst_n = 1'b0;
   logic              wr_en = 1'b0, done_clr = 1'b0, rd_req = 1'b0;
   logic [1:0]        wr_op = 2'd0;
   logic [SEC_W-1:0]  wr_sec = '0;
   logic [NS_W-1:0]   wr_ns = '0;
   logic [FRAC_W-1:0] wr_frac = '0;
   logic              adj_done, rd_valid;
   logic [SEC_W-1:0]  tod_sec, rd_sec;
   logic [NS_W-1:0]   tod_ns, rd_ns;

   tod_clock_core u0 (
      .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n), .wr_en(wr_en), .wr_op(wr_op),
      .wr_sec(wr_sec), .wr_ns(wr_ns), .wr_frac(wr_frac), .done_clr(done_clr),
      .adj_done(adj_done), .tod_sec(tod_sec), .tod_ns(tod_ns),
      .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .rd_req(rd_req),
      .rd_valid(rd_valid), .rd_sec(rd_sec), .rd_ns(rd_ns)
   );

   int n_chk = 0, n_fail = 0, n_valid = 0;
   logic [79:0] exp_q[$];

   task automatic check(input bit ok, input string tag,
                        input longint unsigned act, input longint unsigned exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic cmd(input logic [1:0] op, input logic [SEC_W-1:0] s,
                      input logic [NS_W-1:0] n, input logic [FRAC_W-1:0] f,
                      input logic clr);
      @(negedge rtc_clk);
      wr_en = 1'b1; wr_op = op; wr_sec = s; wr_ns = n; wr_frac = f; done_clr = clr;
      @(negedge rtc_clk);
      wr_en = 1'b0; done_clr = 1'b0;
   endtask

   // driver: queue the expected snapshot, then request it
   task automatic read_expect(input logic [SEC_W-1:0] s, input logic [NS_W-1:0] n,
                              input int hold);
      exp_q.push_back({s, n});
      @(negedge cpu_clk); rd_req = 1'b1;
      repeat (hold) @(negedge cpu_clk);
      rd_req = 1'b0;
      repeat (40) @(negedge cpu_clk);
   endtask

   // monitor: pop and compare each answered read
   initial begin
      forever begin
         @(negedge cpu_clk);
         if (rd_valid) begin
            n_valid++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 unexpected rd_valid", 1, 0);
            end else begin
               logic [79:0] e;
               e = exp_q.pop_front();
               check(rd_sec == e[79:32], "R9 snapshot sec", rd_sec, e[79:32]);
               check(rd_ns == e[31:0], "R9 snapshot ns", rd_ns, e[31:0]);
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      check(1'b0, "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      longint unsigned a, b;
      int v0;
      repeat (3) @(negedge rtc_clk);
      rtc_rst_n = 1'b1; cpu_rst_n = 1'b1;
      @(negedge rtc_clk);
      // R1 reset state
      check(tod_sec == 0, "R1 sec after reset", tod_sec, 0);
      check(tod_ns == 0, "R1 ns after reset", tod_ns, 0);
      check(adj_done == 0, "R1 done after reset", adj_done, 0);
      check(rd_valid == 0, "R1 rd_valid after reset", rd_valid, 0);
      repeat (5) @(negedge rtc_clk);
      check(tod_ns == 0, "R1 frozen with zero step", tod_ns, 0);

      // R2 load
      cmd(2'd0, 48'd5, 32'd1000, '0, 1'b0);
      check(tod_sec == 5, "R2 load sec", tod_sec, 5);
      check(tod_ns == 1000, "R2 load ns", tod_ns, 1000);
      read_expect(48'd5, 32'd1000, 1);

      // R6/R7 positive offset, flag held
      cmd(2'd1, '0, 32'd500, '0, 1'b0);
      check(tod_ns == 1500, "R6 offset +500", tod_ns, 1500);
      check(adj_done == 1, "R7 done raised", adj_done, 1);
      repeat (4) @(negedge rtc_clk);
      check(adj_done == 1, "R7 done held", adj_done, 1);
      check(tod_ns == 1500, "R6 offset applied once", tod_ns, 1500);
      @(negedge rtc_clk); done_clr = 1'b1;
      @(negedge rtc_clk); done_clr = 1'b0;
      check(adj_done == 0, "R7 done cleared", adj_done, 0);

      // R6 negative offset with borrow; R7 offset beats clear
      cmd(2'd1, '0, NS_W'(-2000), '0, 1'b1);
      check(tod_sec == 4, "R6 borrow sec", tod_sec, 4);
      check(tod_ns == 999_999_500, "R6 borrow ns", tod_ns, 999_999_500);
      check(adj_done == 1, "R7 offset wins over clear", adj_done, 1);

      // R9 snapshot, then a held request that must be dropped once busy
      read_expect(48'd4, 32'd999_999_500, 1);
      v0 = n_valid;
      read_expect(48'd4, 32'd999_999_500, 2);
      check(n_valid - v0 == 1, "R9 busy request dropped", n_valid - v0, 1);
      check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

      // R3 integer step of 8
      cmd(2'd2, '0, 32'd8, '0, 1'b0);
      repeat (5) @(negedge rtc_clk);
      a = tod_ns; @(negedge rtc_clk); b = tod_ns;
      check(b - a == 8, "R3 integer step", b - a, 8);

      // R5 rollover
      cmd(2'd0, 48'd7, 32'd999_999_980, '0, 1'b0);
      repeat (2) @(negedge rtc_clk);
      check(tod_ns == 999_999_996, "R5 before rollover", tod_ns, 999_999_996);
      @(negedge rtc_clk);
      check(tod_sec == 8, "R5 rollover sec", tod_sec, 8);
      check(tod_ns == 4, "R5 rollover ns", tod_ns, 4);

      // R8 clear keeps the step
      cmd(2'd3, '0, '0, '0, 1'b0);
      check(tod_sec == 0 && tod_ns == 0, "R8 clear zeroes time", tod_ns, 0);
      repeat (3) @(negedge rtc_clk);
      a = tod_ns; @(negedge rtc_clk); b = tod_ns;
      check(b - a == 8, "R8 step kept after clear", b - a, 8);

      // R4 quarter-modulo fraction: one ns per four cycles
      cmd(2'd2, '0, 32'd0, 38'd64_000_000_000, 1'b0);
      repeat (10) @(negedge rtc_clk);
      a = tod_ns; repeat (400) @(negedge rtc_clk); b = tod_ns;
      check(b - a == 100, "R4 quarter fraction", b - a, 100);

      // R3/R4 integer plus half-modulo fraction
      cmd(2'd2, '0, 32'd3, 38'd128_000_000_000, 1'b0);
      repeat (10) @(negedge rtc_clk);
      a = tod_ns; repeat (200) @(negedge rtc_clk); b = tod_ns;
      check(b - a == 700, "R3 integer plus fraction", b - a, 700);

      summary();
   end
endmodule